// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives three motor phases. Each phase has a pair of output pins. One shared counter sets the PWM period. It runs either upward with a wrap to zero (edge-aligned) or upward then downward (center-aligned). Each phase compares the counter against its own duty value. A phase pair runs in one of two ways. In independent mode both pins follow the comparison. In complementary mode the two pins are driven in opposition, and a programmable gap is inserted at every switch. During that gap both pins are inactive, so the two switches of a half-bridge never conduct at the same time.

Each pin has its own polarity bit and its own manual override. A fault input puts every pin at a programmed safe level at once, without waiting for a clock. The fault stays captured until software clears it. A single-cycle pulse marks a chosen counter value once per period, so an ADC conversion can be started in step with the switching.

The configuration is presented on plain ports. The period, the duty values and the counting mode are captured into shadow registers by a load strobe. They are copied to the working registers only when the counter returns to zero, so an update never cuts a pulse short.

Top module: `pwm3ph`

## Requirements
- R1: In edge-aligned mode (`cfg_center`=0) the counter runs 0..period. One PWM period is period+1 clocks. A phase whose duty satisfies 0 < duty < period is active for exactly duty clocks of each period.
- R2: In center-aligned mode (`cfg_center`=1) the counter runs 0 up to period and back down to 1. One PWM period is 2·period clocks. A phase with 0 < duty < period is active for 2·duty−1 clocks, centred on the counter minimum.
- R3: A duty of zero keeps the phase inactive for the whole period. A duty equal to or greater than the period keeps it active for the whole period.
- R4: `pwm_out` bit 2k is the high pin of pair k and bit 2k+1 is its low pin. With `cfg_compl[k]`=0 both pins of pair k follow the phase comparison.
- R5: With `cfg_compl[k]`=1 the low pin is the opposite of the high pin. At every change of the comparison result, both pins are inactive for exactly `cfg_dead` clocks, after which the newly active pin asserts. Both pins are never active together.
- R6: `cfg_pol[j]`=1 makes pin j active-low. The pin level is the active state XOR the polarity bit.
- R7: While `ovr_en[j]`=1 and no fault is active, pin j shows `ovr_val[j]` as a pin level. The comparison, the gap and the polarity are bypassed.
- R8: While `fault_in`=1, `pwm_out` equals `safe_val` with no clock edge needed. This has priority over the override.
- R9: Once `fault_in` is seen high at a clock edge, `fault_active` stays 1 and `pwm_out` stays at `safe_val`. This lasts until an edge at which `fault_clr`=1 and `fault_in`=0.
- R10: Period, duty and mode values taken in by `cfg_load` first take effect when the counter next returns to zero. The period in progress completes with the old values.
- R11: `adc_trig` is a single-clock pulse one clock after the counter equals `cfg_trig` while counting upward. This happens once per period.
- R12: During reset all working values are zero and `adc_trig` and `fault_active` are 0. With all override, polarity and fault inputs at 0, every pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Captures period, duty and mode into the shadow registers |
| cfg_period | input | CNT_W | Period value |
| cfg_duty | input | NPAIR·CNT_W | Duty values, pair k in slice k |
| cfg_center | input | 1 | 1 selects center-aligned counting |
| cfg_trig | input | CNT_W | Counter value that fires `adc_trig` |
| cfg_compl | input | NPAIR | Complementary mode per pair |
| cfg_dead | input | DT_W | Gap length in clocks |
| cfg_pol | input | 2·NPAIR | Per-pin active-low select |
| ovr_en | input | 2·NPAIR | Per-pin override enable |
| ovr_val | input | 2·NPAIR | Per-pin override level |
| safe_val | input | 2·NPAIR | Per-pin level during a fault |
| fault_in | input | 1 | Fault request, active high |
| fault_clr | input | 1 | Releases a captured fault |
| pwm_out | output | 2·NPAIR | Pin levels |
| adc_trig | output | 1 | Conversion start pulse |
| fault_active | output | 1 | Fault present or captured |

## Verification
The bench builds the block with its defaults: a 16-bit counter, an 8-bit gap counter and three pairs. It drives periods of 6 to 19 clocks, so that every period can be counted cycle by cycle. At that scale the wrap, the turn at the top of a center-aligned count, the zero and full duty limits, and gaps of 1 to 3 clocks all appear within a few tens of clocks. The same measurement across all three pairs also shows that the pairs are built alike.

// File: rtl/pwm3ph_pkg.sv
package pwm3ph_pkg;
  typedef enum logic {
    TB_EDGE   = 1'b0,
    TB_CENTER = 1'b1
  } tb_mode_e;
endpackage

// File: rtl/pwm3ph_timebase.sv
module pwm3ph_timebase
  import pwm3ph_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NPAIR = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_load,
  input  logic [CNT_W-1:0]       cfg_period,
  input  logic [NPAIR*CNT_W-1:0] cfg_duty,
  input  logic                   cfg_center,
  input  logic [CNT_W-1:0]       cfg_trig,
  output logic [NPAIR-1:0]       raw_o,
  output logic                   trig_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   up_q, up_d;
  logic                   wrap;
  logic [CNT_W-1:0]       per_sh_q, per_act_q;
  logic [NPAIR*CNT_W-1:0] duty_sh_q, duty_act_q;
  tb_mode_e               mode_sh_q, mode_act_q;
  logic                   trig_q, trig_d;

  // next state of the counter
  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    wrap  = 1'b0;
    if (mode_act_q == TB_EDGE) begin
      up_d = 1'b1;
      if (cnt_q >= per_act_q) begin
        cnt_d = '0;
        wrap  = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else if (up_q) begin
      if (cnt_q >= per_act_q) begin
        if (per_act_q <= ONE) begin
          cnt_d = '0;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
          up_d  = 1'b0;
        end
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else begin
      if (cnt_q <= ONE) begin
        cnt_d = '0;
        up_d  = 1'b1;
        wrap  = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
    trig_d = up_q && (cnt_q == cfg_trig);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      trig_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      up_q   <= up_d;
      trig_q <= trig_d;
    end
  end

  // shadow registers, enabled by the load strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh_q  <= '0;
      duty_sh_q <= '0;
      mode_sh_q <= TB_EDGE;
    end else if (cfg_load) begin
      per_sh_q  <= cfg_period;
      duty_sh_q <= cfg_duty;
      mode_sh_q <= cfg_center ? TB_CENTER : TB_EDGE;
    end
  end

  // working registers, enabled at the counter wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_act_q  <= '0;
      duty_act_q <= '0;
      mode_act_q <= TB_EDGE;
    end else if (wrap) begin
      per_act_q  <= per_sh_q;
      duty_act_q <= duty_sh_q;
      mode_act_q <= mode_sh_q;
    end
  end

  for (genvar k = 0; k < NPAIR; k++) begin : g_cmp
    logic [CNT_W-1:0] duty_k;
    assign duty_k   = duty_act_q[k*CNT_W +: CNT_W];
    assign raw_o[k] = (duty_k != '0) && ((duty_k >= per_act_q) || (cnt_q < duty_k));
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/pwm3ph_deadband.sv
module pwm3ph_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw_i,
  input  logic            compl_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            hi_o,
  output logic            lo_o
);
  logic            ref_q, ref_d;
  logic [DT_W-1:0] gap_q, gap_d;
  logic            gap_done;

  always_comb begin
    ref_d = raw_i;
    gap_d = gap_q;
    if (raw_i != ref_q) begin
      gap_d = dead_i;
    end else if (gap_q != '0) begin
      gap_d = gap_q - DT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      gap_q <= '0;
    end else begin
      ref_q <= ref_d;
      gap_q <= gap_d;
    end
  end

  assign gap_done = (gap_q == '0);
  assign hi_o     = compl_i ? (ref_q && gap_done)  : ref_q;
  assign lo_o     = compl_i ? (!ref_q && gap_done) : ref_q;
endmodule

// File: rtl/pwm3ph_faultlatch.sv
module pwm3ph_faultlatch (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic clr_i,
  output logic active_o
);
  logic held_q, held_d;

  always_comb begin
    held_d = held_q;
    if (fault_i) begin
      held_d = 1'b1;
    end else if (clr_i) begin
      held_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else begin
      held_q <= held_d;
    end
  end

  assign active_o = held_q | fault_i;
endmodule

// File: rtl/pwm3ph.sv
module pwm3ph #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8,
  parameter int NPAIR = 3,
  localparam int NPIN = 2 * NPAIR
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_load,
  input  logic [CNT_W-1:0]       cfg_period,
  input  logic [NPAIR*CNT_W-1:0] cfg_duty,
  input  logic                   cfg_center,
  input  logic [CNT_W-1:0]       cfg_trig,
  input  logic [NPAIR-1:0]       cfg_compl,
  input  logic [DT_W-1:0]        cfg_dead,
  input  logic [NPIN-1:0]        cfg_pol,
  input  logic [NPIN-1:0]        ovr_en,
  input  logic [NPIN-1:0]        ovr_val,
  input  logic [NPIN-1:0]        safe_val,
  input  logic                   fault_in,
  input  logic                   fault_clr,
  output logic [NPIN-1:0]        pwm_out,
  output logic                   adc_trig,
  output logic                   fault_active
);
  logic [1:0]       rst_sync_q;
  logic             rst_ns;
  logic [NPAIR-1:0] raw;
  logic [NPIN-1:0]  act;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ns = rst_sync_q[1];

  pwm3ph_timebase #(
    .CNT_W(CNT_W),
    .NPAIR(NPAIR)
  ) tb_i (
    .clk       (clk),
    .rst_n     (rst_ns),
    .cfg_load  (cfg_load),
    .cfg_period(cfg_period),
    .cfg_duty  (cfg_duty),
    .cfg_center(cfg_center),
    .cfg_trig  (cfg_trig),
    .raw_o     (raw),
    .trig_o    (adc_trig)
  );

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    pwm3ph_deadband #(
      .DT_W(DT_W)
    ) db_i (
      .clk    (clk),
      .rst_n  (rst_ns),
      .raw_i  (raw[k]),
      .compl_i(cfg_compl[k]),
      .dead_i (cfg_dead),
      .hi_o   (act[2*k]),
      .lo_o   (act[2*k+1])
    );
  end

  pwm3ph_faultlatch flt_i (
    .clk     (clk),
    .rst_n   (rst_ns),
    .fault_i (fault_in),
    .clr_i   (fault_clr),
    .active_o(fault_active)
  );

  // output stage: fault, then override, then polarity
  for (genvar j = 0; j < NPIN; j++) begin : g_pin
    always_comb begin
      if (fault_active) begin
        pwm_out[j] = safe_val[j];
      end else if (ovr_en[j]) begin
        pwm_out[j] = ovr_val[j];
      end else begin
        pwm_out[j] = act[j] ^ cfg_pol[j];
      end
    end
  end
endmodule

// File: rtl/pwm3ph_chk.sv
module pwm3ph_chk #(
  parameter int NPAIR = 3,
  localparam int NPIN = 2 * NPAIR
) (
  input logic            clk,
  input logic            rst_q,
  input logic            fault_in,
  input logic            fault_active,
  input logic [NPAIR-1:0] cfg_compl,
  input logic [NPIN-1:0] cfg_pol,
  input logic [NPIN-1:0] ovr_en,
  input logic [NPIN-1:0] ovr_val,
  input logic [NPIN-1:0] safe_val,
  input logic [NPIN-1:0] pwm_out
);
  // R8
  fault_safe_chk: assert property (@(posedge clk) disable iff (!rst_q)
    fault_in |-> (pwm_out == safe_val));

  // R9
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && $past(fault_in)) |-> fault_active);

  for (genvar j = 0; j < NPIN; j++) begin : g_pin_chk
    // R7
    ovr_level_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (!fault_active && ovr_en[j]) |-> (pwm_out[j] == ovr_val[j]));
  end

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair_chk
    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (cfg_compl[k] && !fault_active && !ovr_en[2*k] && !ovr_en[2*k+1])
        |-> !((pwm_out[2*k] ^ cfg_pol[2*k]) && (pwm_out[2*k+1] ^ cfg_pol[2*k+1])));
  end
endmodule

bind pwm3ph pwm3ph_chk #(
  .NPAIR(NPAIR)
) chk_i (
  .clk         (clk),
  .rst_q       (rst_ns),
  .fault_in    (fault_in),
  .fault_active(fault_active),
  .cfg_compl   (cfg_compl),
  .cfg_pol     (cfg_pol),
  .ovr_en      (ovr_en),
  .ovr_val     (ovr_val),
  .safe_val    (safe_val),
  .pwm_out     (pwm_out)
);

// File: tb/pwm3ph_tb_top.sv
`timescale 1ns/1ps
module pwm3ph_tb_top;
  localparam int CNT_W = 16;
  localparam int DT_W  = 8;
  localparam int NPAIR = 3;
  localparam int NPIN  = 2 * NPAIR;

  typedef struct packed {
    logic        center;
    logic        compl;
    logic [15:0] per;
    logic [15:0] duty;
    logic [7:0]  dead;
    logic [15:0] exp_p;
    logic [15:0] exp_h;
    logic [15:0] exp_l;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b0, 16'd9,  16'd4, 8'd0, 16'd10, 16'd4,  16'd4},
    '{1'b0, 1'b1, 16'd9,  16'd4, 8'd2, 16'd10, 16'd2,  16'd4},
    '{1'b0, 1'b1, 16'd9,  16'd0, 8'd2, 16'd10, 16'd0,  16'd10},
    '{1'b0, 1'b1, 16'd9,  16'd9, 8'd2, 16'd10, 16'd10, 16'd0},
    '{1'b1, 1'b1, 16'd8,  16'd3, 8'd1, 16'd16, 16'd4,  16'd10},
    '{1'b1, 1'b0, 16'd8,  16'd0, 8'd0, 16'd16, 16'd0,  16'd0},
    '{1'b1, 1'b0, 16'd6,  16'd6, 8'd0, 16'd12, 16'd12, 16'd12},
    '{1'b0, 1'b1, 16'd15, 16'd8, 8'd3, 16'd16, 16'd5,  16'd5}
  };

  logic                   clk;
  logic                   rst_n;
  logic                   cfg_load;
  logic [CNT_W-1:0]       cfg_period;
  logic [NPAIR*CNT_W-1:0] cfg_duty;
  logic                   cfg_center;
  logic [CNT_W-1:0]       cfg_trig;
  logic [NPAIR-1:0]       cfg_compl;
  logic [DT_W-1:0]        cfg_dead;
  logic [NPIN-1:0]        cfg_pol;
  logic [NPIN-1:0]        ovr_en;
  logic [NPIN-1:0]        ovr_val;
  logic [NPIN-1:0]        safe_val;
  logic                   fault_in;
  logic                   fault_clr;
  logic [NPIN-1:0]        pwm_out;
  logic                   adc_trig;
  logic                   fault_active;

  int n_chk;
  int n_fail;

  pwm3ph #(
    .CNT_W(CNT_W),
    .DT_W (DT_W),
    .NPAIR(NPAIR)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load    (cfg_load),
    .cfg_period  (cfg_period),
    .cfg_duty    (cfg_duty),
    .cfg_center  (cfg_center),
    .cfg_trig    (cfg_trig),
    .cfg_compl   (cfg_compl),
    .cfg_dead    (cfg_dead),
    .cfg_pol     (cfg_pol),
    .ovr_en      (ovr_en),
    .ovr_val     (ovr_val),
    .safe_val    (safe_val),
    .fault_in    (fault_in),
    .fault_clr   (fault_clr),
    .pwm_out     (pwm_out),
    .adc_trig    (adc_trig),
    .fault_active(fault_active)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_cfg(input logic center, input logic compl, input int per,
                          input int duty, input int dead);
    cfg_center = center;
    cfg_compl  = {NPAIR{compl}};
    cfg_period = CNT_W'(per);
    cfg_duty   = {NPAIR{CNT_W'(duty)}};
    cfg_dead   = DT_W'(dead);
    @(negedge clk);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    wait_cyc(80);
  endtask

  // measures one period from trigger to trigger, counting active cycles per pin
  task automatic measure(output int p, output int hc [NPAIR], output int lc [NPAIR]);
    int guard;
    guard = 0;
    while (!adc_trig && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    p = 0;
    for (int k = 0; k < NPAIR; k++) begin
      hc[k] = 0;
      lc[k] = 0;
    end
    forever begin
      for (int k = 0; k < NPAIR; k++) begin
        hc[k] += int'(pwm_out[2*k]);
        lc[k] += int'(pwm_out[2*k+1]);
      end
      p++;
      @(negedge clk);
      if (adc_trig || p > 1000) break;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    report();
  end

  initial begin
    int p;
    int hc [NPAIR];
    int lc [NPAIR];
    int n;
    int pulses;
    int twice;
    logic prev;
    n_chk  = 0;
    n_fail = 0;
    rst_n      = 1'b0;
    cfg_load   = 1'b0;
    cfg_period = '0;
    cfg_duty   = '0;
    cfg_center = 1'b0;
    cfg_trig   = '0;
    cfg_compl  = '0;
    cfg_dead   = '0;
    cfg_pol    = '0;
    ovr_en     = '0;
    ovr_val    = '0;
    safe_val   = '0;
    fault_in   = 1'b0;
    fault_clr  = 1'b0;
    wait_cyc(4);
    // R12 reset state
    chk("R12 pwm_out in reset", int'(pwm_out), 0);
    chk("R12 adc_trig in reset", int'(adc_trig), 0);
    chk("R12 fault_active in reset", int'(fault_active), 0);
    rst_n = 1'b1;
    wait_cyc(5);

    // vector table: R1 R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      load_cfg(VEC[v].center, VEC[v].compl, int'(VEC[v].per), int'(VEC[v].duty),
               int'(VEC[v].dead));
      measure(p, hc, lc);
      chk(VEC[v].center ? "R2 period length" : "R1 period length", p, int'(VEC[v].exp_p));
      for (int k = 0; k < NPAIR; k++) begin
        chk(VEC[v].compl ? "R5 high pin count" : "R4 high pin count", hc[k],
            int'(VEC[v].exp_h));
        chk(VEC[v].compl ? "R5 low pin count" : "R4 low pin count", lc[k],
            int'(VEC[v].exp_l));
      end
    end

    // R10 double buffering: new period only after the running one ends
    load_cfg(1'b0, 1'b0, 9, 4, 0);
    measure(p, hc, lc);
    cfg_period = CNT_W'(19);
    cfg_load   = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    n = 1;
    while (!adc_trig && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R10 old period completes", n, 10);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!adc_trig && n < 100);
    chk("R10 new period applied", n, 20);

    // R11 trigger position and width
    load_cfg(1'b0, 1'b0, 9, 4, 0);
    cfg_trig = CNT_W'(5);
    wait_cyc(20);
    pulses = 0;
    twice  = 0;
    prev   = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (adc_trig) pulses++;
      if (adc_trig && prev) twice++;
      prev = adc_trig;
      @(negedge clk);
    end
    chk("R11 pulses in three periods", pulses, 3);
    chk("R11 single-cycle pulse", twice, 0);
    cfg_trig = '0;

    // R6 polarity, steady inactive phases
    load_cfg(1'b0, 1'b0, 9, 0, 0);
    cfg_pol = 6'b111111;
    wait_cyc(2);
    chk("R6 all active-low", int'(pwm_out), 6'h3F);
    cfg_pol = 6'b000101;
    wait_cyc(2);
    chk("R6 mixed polarity", int'(pwm_out), 6'h05);
    cfg_pol = '0;

    // R7 override
    ovr_en  = 6'b001000;
    ovr_val = 6'b001000;
    wait_cyc(2);
    chk("R7 override high over inactive", int'(pwm_out), 6'h08);
    load_cfg(1'b0, 1'b0, 9, 9, 0);
    ovr_en  = 6'b000001;
    ovr_val = 6'b000000;
    wait_cyc(2);
    chk("R7 override low over active", int'(pwm_out), 6'h3E);
    ovr_en = '0;
    wait_cyc(2);
    chk("R7 override released", int'(pwm_out), 6'h3F);

    // R8 R9 fault
    safe_val = 6'b010101;
    ovr_en   = 6'b000010;
    ovr_val  = 6'b000000;
    @(negedge clk);
    fault_in = 1'b1;
    #1;
    chk("R8 safe level without clock", int'(pwm_out), 6'h15);
    wait_cyc(3);
    fault_in = 1'b0;
    wait_cyc(4);
    chk("R9 fault held after input drops", int'(fault_active), 1);
    chk("R9 safe level held", int'(pwm_out), 6'h15);
    fault_in  = 1'b1;
    fault_clr = 1'b1;
    wait_cyc(2);
    fault_in = 1'b0;
    #1;
    chk("R9 clear ignored while input high", int'(pwm_out), 6'h15);
    @(negedge clk);
    fault_clr = 1'b0;
    chk("R9 released by clear", int'(fault_active), 0);
    chk("R9 outputs back to normal", int'(pwm_out), 6'h3D);
    ovr_en = '0;
    wait_cyc(2);

    report();
  end
endmodule